// File: doc/BRIEF.md
# CPU/DMA Shared-Interface Access Arbiter

This block sits between a processor port and a DMA port that both reach a set of memory blocks and peripheral frames. Each port offers one access per cycle, made of a request, a target interface number, an address, a write flag and write data. Every cycle the arbiter decides, for each interface, which port may use it. The winning access is forwarded one cycle later on a registered lane together with a one-cycle grant bit for that interface. A processor access that is not accepted raises a stall, and the processor holds its request until it is accepted. A DMA access that is not accepted raises a hold, with the same meaning.

An interface stays occupied for a fixed number of cycles once it has been granted. During that time no new access starts on it, so an access in progress is never cut short. When the interface frees up, the DMA wins over a processor access that was queued behind it. One interface, a bank of converter results, takes reads from both ports in the same cycle and never counts as occupied by a read. Writes to it are arbitrated like writes to any other interface.

Top module: `arb_shared_if`

## Requirements
- R1: Reset clears every grant bit, every forwarded lane and every occupancy. After reset is released, any interface accepts a request in the first cycle.
- R2: When both ports request the same interface in the same cycle and it is free, the DMA is granted and the processor stalls. This does not apply when both accesses are reads of the converter interface.
- R3: Requests to different free interfaces are both accepted in the same cycle. Neither port stalls, and both grant bits are set in the next cycle.
- R4: A granted access occupies its interface for ACC_CYC cycles, counting the cycle of acceptance (default 2). Any request to it during that time is stalled or held, and the access in progress is never dropped.
- R5: When a processor access is in progress and a second processor access to the same interface waits, a DMA request to that interface is accepted ahead of the waiting processor access as soon as the interface frees.
- R6: The converter interface is interface number 7 (parameter EXEMPT_IF). Reads of it by both ports in the same cycle are both accepted, even at different addresses. A read never occupies it, so reads can be accepted on back-to-back cycles.
- R7: A write to the converter interface is arbitrated as a normal access. It loses to a same-cycle DMA access there, and it occupies the interface for ACC_CYC cycles, which blocks reads from the other port.
- R8: cpu_stall is high in every cycle in which cpu_req is high and the access is not accepted, and low otherwise. dma_hold behaves the same way for the DMA port. A grant bit appears exactly one cycle after a cycle with the request high and the stall or hold low.
- R9: Grant bits last one cycle per access. Except for the dual read of R6, at most one of the two grant bits of an interface is set in any cycle. Bit i of if_cpu_gnt and if_dma_gnt stands for interface i.
- R10: In the cycle a grant bit is set, the lane of that port carries the address, write flag and write data that were accepted in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request |
| cpu_if | input | IF_W | Processor target interface number |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_we | input | 1 | Processor write flag (1 = write) |
| cpu_wdata | input | DATA_W | Processor write data |
| dma_req | input | 1 | DMA access request |
| dma_if | input | IF_W | DMA target interface number |
| dma_addr | input | ADDR_W | DMA address |
| dma_we | input | 1 | DMA write flag (1 = write) |
| dma_wdata | input | DATA_W | DMA write data |
| cpu_stall | output | 1 | Processor request not accepted this cycle |
| dma_hold | output | 1 | DMA request not accepted this cycle |
| if_cpu_gnt | output | N_IF | Per-interface processor grant, one-cycle pulse |
| if_dma_gnt | output | N_IF | Per-interface DMA grant, one-cycle pulse |
| out_cpu_addr | output | ADDR_W | Forwarded processor address |
| out_cpu_we | output | 1 | Forwarded processor write flag |
| out_cpu_wdata | output | DATA_W | Forwarded processor write data |
| out_dma_addr | output | ADDR_W | Forwarded DMA address |
| out_dma_we | output | 1 | Forwarded DMA write flag |
| out_dma_wdata | output | DATA_W | Forwarded DMA write data |

## Verification
The arbitration is driven with several request patterns. Both ports aiming at different interfaces shows that the two ports do not block each other. Both ports aiming at the same free interface shows that the DMA wins. Requests arriving while an interface is still occupied show that an access in progress is not dropped. A processor access that waits behind its own earlier access while the DMA joins shows that the DMA goes ahead of the queued processor access. On the converter interface, paired reads, then a write against a read, then a read against an earlier write separate the conflict-free read path from normal arbitration. A reset in the middle of an occupancy shows that reset leaves no interface occupied.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [0:0] {
    OWN_CPU = 1'b0,
    OWN_DMA = 1'b1
  } owner_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/arb_busy.sv
module arb_busy #(
  parameter int N_IF    = 8,
  parameter int ACC_CYC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IF-1:0] occ,
  output logic [N_IF-1:0] free
);
  localparam int CNT_W = $clog2(ACC_CYC + 1);

  for (genvar i = 0; i < N_IF; i++) begin : g_if
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst)               cnt <= '0;
      else if (occ[i])       cnt <= CNT_W'(ACC_CYC - 1);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign free[i] = (cnt == '0);

    // An occupying grant is only ever given to a free interface.
    assert_no_start_busy_R4: assert property (@(posedge clk) disable iff (rst)
      !free[i] |-> !occ[i]);

    if (ACC_CYC > 1) begin : g_hold
      assert_occupied_after_grant_R4: assert property (@(posedge clk) disable iff (rst)
        occ[i] |=> !free[i]);
    end
  end
endmodule

// File: rtl/arb_decide.sv
module arb_decide #(
  parameter int N_IF      = 8,
  parameter int EXEMPT_IF = 7,
  parameter int IF_W      = 3
) (
  input  logic            cpu_req,
  input  logic [IF_W-1:0] cpu_if,
  input  logic            cpu_we,
  input  logic            dma_req,
  input  logic [IF_W-1:0] dma_if,
  input  logic            dma_we,
  input  logic [N_IF-1:0] free,
  output logic            cpu_ok,
  output logic            dma_ok,
  output logic [N_IF-1:0] occ
);
  localparam logic [IF_W-1:0] XIF = IF_W'(EXEMPT_IF);

  logic same_if, dual_read, cpu_xrd, dma_xrd;

  always_comb begin
    cpu_xrd   = (cpu_if == XIF) && !cpu_we;
    dma_xrd   = (dma_if == XIF) && !dma_we;
    same_if   = cpu_req && dma_req && (cpu_if == dma_if);
    dual_read = same_if && cpu_xrd && dma_xrd;
    dma_ok    = dma_req && free[dma_if];
    cpu_ok    = cpu_req && free[cpu_if] && (!same_if || dual_read);
    occ       = '0;
    if (cpu_ok && !cpu_xrd) occ = occ | (N_IF'(1) << cpu_if);
    if (dma_ok && !dma_xrd) occ = occ | (N_IF'(1) << dma_if);
  end
endmodule

// File: rtl/arb_issue.sv
module arb_issue #(
  parameter int N_IF   = 8,
  parameter int IF_W   = 3,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_ok,
  input  logic [IF_W-1:0]   cpu_if,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              dma_ok,
  input  logic [IF_W-1:0]   dma_if,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic              dma_we,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic [N_IF-1:0]   gnt_cpu,
  output logic [N_IF-1:0]   gnt_dma,
  output logic [ADDR_W-1:0] o_cpu_addr,
  output logic              o_cpu_we,
  output logic [DATA_W-1:0] o_cpu_wdata,
  output logic [ADDR_W-1:0] o_dma_addr,
  output logic              o_dma_we,
  output logic [DATA_W-1:0] o_dma_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_cpu     <= '0;
      gnt_dma     <= '0;
      o_cpu_addr  <= '0;
      o_cpu_we    <= 1'b0;
      o_cpu_wdata <= '0;
      o_dma_addr  <= '0;
      o_dma_we    <= 1'b0;
      o_dma_wdata <= '0;
    end else begin
      gnt_cpu <= cpu_ok ? (N_IF'(1) << cpu_if) : '0;
      gnt_dma <= dma_ok ? (N_IF'(1) << dma_if) : '0;
      if (cpu_ok) begin
        o_cpu_addr  <= cpu_addr;
        o_cpu_we    <= cpu_we;
        o_cpu_wdata <= cpu_wdata;
      end
      if (dma_ok) begin
        o_dma_addr  <= dma_addr;
        o_dma_we    <= dma_we;
        o_dma_wdata <= dma_wdata;
      end
    end
  end
endmodule

// File: rtl/arb_shared_if.sv
module arb_shared_if #(
  parameter int N_IF      = 8,
  parameter int EXEMPT_IF = 7,
  parameter int ACC_CYC   = 2,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int IF_W      = arb_pkg::idx_w(N_IF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic [IF_W-1:0]   cpu_if,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              dma_req,
  input  logic [IF_W-1:0]   dma_if,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic              dma_we,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              cpu_stall,
  output logic              dma_hold,
  output logic [N_IF-1:0]   if_cpu_gnt,
  output logic [N_IF-1:0]   if_dma_gnt,
  output logic [ADDR_W-1:0] out_cpu_addr,
  output logic              out_cpu_we,
  output logic [DATA_W-1:0] out_cpu_wdata,
  output logic [ADDR_W-1:0] out_dma_addr,
  output logic              out_dma_we,
  output logic [DATA_W-1:0] out_dma_wdata
);
  logic [N_IF-1:0] free, occ;
  logic            cpu_ok, dma_ok;

  arb_busy #(.N_IF(N_IF), .ACC_CYC(ACC_CYC)) u_busy (
    .clk(clk), .rst(rst), .occ(occ), .free(free)
  );

  arb_decide #(.N_IF(N_IF), .EXEMPT_IF(EXEMPT_IF), .IF_W(IF_W)) u_decide (
    .cpu_req(cpu_req), .cpu_if(cpu_if), .cpu_we(cpu_we),
    .dma_req(dma_req), .dma_if(dma_if), .dma_we(dma_we),
    .free(free), .cpu_ok(cpu_ok), .dma_ok(dma_ok), .occ(occ)
  );

  arb_issue #(.N_IF(N_IF), .IF_W(IF_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
    .clk(clk), .rst(rst),
    .cpu_ok(cpu_ok), .cpu_if(cpu_if), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata),
    .dma_ok(dma_ok), .dma_if(dma_if), .dma_addr(dma_addr), .dma_we(dma_we),
    .dma_wdata(dma_wdata),
    .gnt_cpu(if_cpu_gnt), .gnt_dma(if_dma_gnt),
    .o_cpu_addr(out_cpu_addr), .o_cpu_we(out_cpu_we), .o_cpu_wdata(out_cpu_wdata),
    .o_dma_addr(out_dma_addr), .o_dma_we(out_dma_we), .o_dma_wdata(out_dma_wdata)
  );

  assign cpu_stall = cpu_req && !cpu_ok;
  assign dma_hold  = dma_req && !dma_ok;

  assert_stall_no_grant_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |=> (if_cpu_gnt == '0));
  assert_accept_grants_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_stall) |=> (if_cpu_gnt != '0));
  assert_dma_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dma_hold) |=> $onehot(if_dma_gnt));
  assert_dma_wins_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && dma_req && cpu_if == dma_if && !dma_hold &&
     (cpu_we || dma_we || cpu_if != IF_W'(EXEMPT_IF))) |-> cpu_stall);
  assert_lane_addr_R10: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_stall) |=> (out_cpu_addr == $past(cpu_addr)));
  assert_lane_dma_R10: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dma_hold) |=> (out_dma_wdata == $past(dma_wdata)));

  for (genvar i = 0; i < N_IF; i++) begin : g_chk
    if (i != EXEMPT_IF) begin : g_plain
      assert_one_owner_R9: assert property (@(posedge clk) disable iff (rst)
        !(if_cpu_gnt[i] && if_dma_gnt[i]));
      if (ACC_CYC > 1) begin : g_pulse
        assert_grant_pulse_R9: assert property (@(posedge clk) disable iff (rst)
          (if_cpu_gnt[i] || if_dma_gnt[i]) |=> !(if_cpu_gnt[i] || if_dma_gnt[i]));
      end
    end
  end
endmodule

// File: tb/sim_arb_shared_if.sv
module sim_arb_shared_if;
  localparam int CLK_NS = 10;
  localparam int NV     = 21;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, dma_req = 1'b0, cpu_we = 1'b0, dma_we = 1'b0;
  logic [2:0]  cpu_if = '0, dma_if = '0;
  logic [15:0] cpu_addr = '0, dma_addr = '0, cpu_wdata = '0, dma_wdata = '0;
  logic        cpu_stall, dma_hold, out_cpu_we, out_dma_we;
  logic [7:0]  if_cpu_gnt, if_dma_gnt;
  logic [15:0] out_cpu_addr, out_cpu_wdata, out_dma_addr, out_dma_wdata;

  int n_chk = 0, n_bad = 0;

  always #(CLK_NS / 2) clk = ~clk;

  arb_shared_if u0 (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_if(cpu_if), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata),
    .dma_req(dma_req), .dma_if(dma_if), .dma_addr(dma_addr), .dma_we(dma_we),
    .dma_wdata(dma_wdata),
    .cpu_stall(cpu_stall), .dma_hold(dma_hold),
    .if_cpu_gnt(if_cpu_gnt), .if_dma_gnt(if_dma_gnt),
    .out_cpu_addr(out_cpu_addr), .out_cpu_we(out_cpu_we), .out_cpu_wdata(out_cpu_wdata),
    .out_dma_addr(out_dma_addr), .out_dma_we(out_dma_we), .out_dma_wdata(out_dma_wdata)
  );

  // [31]creq [30:28]cif [27]cwe [26]dreq [25:23]dif [22]dwe
  // [21]exp stall [20]exp hold [19:12]exp cpu grant [11:4]exp dma grant [3:0]req
  localparam logic [31:0] VEC [NV] = '{
    {1'b1,3'd0,1'b0, 1'b1,3'd1,1'b1, 1'b0,1'b0, 8'h01,8'h02, 4'd3},  // R3
    {1'b1,3'd0,1'b0, 1'b1,3'd1,1'b1, 1'b1,1'b1, 8'h00,8'h00, 4'd4},  // R4
    {1'b1,3'd0,1'b0, 1'b1,3'd1,1'b1, 1'b0,1'b0, 8'h01,8'h02, 4'd4},  // R4
    {1'b0,3'd0,1'b0, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h00,8'h00, 4'd8},  // R8
    {1'b1,3'd2,1'b0, 1'b1,3'd2,1'b0, 1'b1,1'b0, 8'h00,8'h04, 4'd2},  // R2
    {1'b1,3'd2,1'b0, 1'b0,3'd0,1'b0, 1'b1,1'b0, 8'h00,8'h00, 4'd4},  // R4
    {1'b1,3'd2,1'b0, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h04,8'h00, 4'd4},  // R4
    {1'b1,3'd2,1'b1, 1'b1,3'd2,1'b0, 1'b1,1'b1, 8'h00,8'h00, 4'd4},  // R4 DMA waits
    {1'b1,3'd2,1'b1, 1'b1,3'd2,1'b0, 1'b1,1'b0, 8'h00,8'h04, 4'd5},  // R5
    {1'b1,3'd2,1'b1, 1'b0,3'd0,1'b0, 1'b1,1'b0, 8'h00,8'h00, 4'd5},  // R5
    {1'b1,3'd2,1'b1, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h04,8'h00, 4'd5},  // R5
    {1'b0,3'd0,1'b0, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h00,8'h00, 4'd8},  // R8
    {1'b1,3'd7,1'b0, 1'b1,3'd7,1'b0, 1'b0,1'b0, 8'h80,8'h80, 4'd6},  // R6
    {1'b1,3'd7,1'b0, 1'b1,3'd7,1'b0, 1'b0,1'b0, 8'h80,8'h80, 4'd6},  // R6
    {1'b1,3'd7,1'b1, 1'b1,3'd7,1'b0, 1'b1,1'b0, 8'h00,8'h80, 4'd7},  // R7
    {1'b1,3'd7,1'b1, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h80,8'h00, 4'd7},  // R7
    {1'b0,3'd0,1'b0, 1'b1,3'd7,1'b0, 1'b0,1'b1, 8'h00,8'h00, 4'd7},  // R7
    {1'b0,3'd0,1'b0, 1'b1,3'd7,1'b0, 1'b0,1'b0, 8'h00,8'h80, 4'd7},  // R7
    {1'b0,3'd0,1'b0, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h00,8'h00, 4'd9},  // R9
    {1'b1,3'd3,1'b1, 1'b1,3'd4,1'b1, 1'b0,1'b0, 8'h08,8'h10, 4'd3},  // R3
    {1'b1,3'd7,1'b0, 1'b1,3'd6,1'b0, 1'b0,1'b0, 8'h80,8'h40, 4'd3}   // R3
  };

  task automatic chk(input bit ok, input int req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic cr, input logic [2:0] ci, input logic cw,
                       input logic dr, input logic [2:0] di, input logic dw,
                       input int k);
    cpu_req = cr; cpu_if = ci; cpu_we = cw;
    dma_req = dr; dma_if = di; dma_we = dw;
    cpu_addr  = 16'h1000 + 16'(k); cpu_wdata = 16'hA000 + 16'(k);
    dma_addr  = 16'h2000 + 16'(k); dma_wdata = 16'hB000 + 16'(k);
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R1: outputs cleared while in reset
    chk(if_cpu_gnt == 0 && if_dma_gnt == 0, 1, {if_cpu_gnt, if_dma_gnt}, 0, "grants in reset");
    chk(out_cpu_addr == 0 && out_dma_wdata == 0, 1, {out_cpu_addr, out_dma_wdata}, 0, "lanes in reset");
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      logic [31:0] v;
      int rq;
      v  = VEC[k];
      rq = int'(v[3:0]);
      drive(v[31], v[30:28], v[27], v[26], v[25:23], v[22], k);
      #1;
      // R8: stall and hold reflect acceptance in the same cycle
      chk(cpu_stall == v[21], (rq == 8) ? 8 : rq, 32'(cpu_stall), 32'(v[21]), $sformatf("cpu_stall v%0d", k));
      chk(dma_hold == v[20], (rq == 8) ? 8 : rq, 32'(dma_hold), 32'(v[20]), $sformatf("dma_hold v%0d", k));
      @(posedge clk);
      #1;
      chk(if_cpu_gnt == v[19:12], rq, 32'(if_cpu_gnt), 32'(v[19:12]), $sformatf("cpu grant v%0d", k));
      chk(if_dma_gnt == v[11:4], rq, 32'(if_dma_gnt), 32'(v[11:4]), $sformatf("dma grant v%0d", k));
      // R10: lanes carry the accepted access
      if (v[19:12] != 0)
        chk(out_cpu_addr == 16'h1000 + 16'(k) && out_cpu_wdata == 16'hA000 + 16'(k) && out_cpu_we == v[27],
            10, {out_cpu_addr, out_cpu_wdata}, {16'h1000 + 16'(k), 16'hA000 + 16'(k)}, $sformatf("cpu lane v%0d", k));
      if (v[11:4] != 0)
        chk(out_dma_addr == 16'h2000 + 16'(k) && out_dma_wdata == 16'hB000 + 16'(k) && out_dma_we == v[22],
            10, {out_dma_addr, out_dma_wdata}, {16'h2000 + 16'(k), 16'hB000 + 16'(k)}, $sformatf("dma lane v%0d", k));
    end

    // R1: reset in the middle of an occupancy leaves the interface free
    drive(1'b1, 3'd5, 1'b1, 1'b0, 3'd0, 1'b0, 40);
    @(posedge clk); #1;
    chk(if_cpu_gnt == 8'h20, 1, 32'(if_cpu_gnt), 32'h20, "grant before reset");
    rst = 1'b1;
    drive(1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 41);
    @(posedge clk); #1;
    chk(if_cpu_gnt == 0 && out_cpu_addr == 0, 1, {if_cpu_gnt, out_cpu_addr}, 0, "reset clears grant and lane");
    rst = 1'b0;
    drive(1'b1, 3'd5, 1'b0, 1'b1, 3'd5, 1'b0, 42);
    #1;
    // R2: interface free right after reset, DMA wins the same-cycle clash
    chk(dma_hold == 1'b0 && cpu_stall == 1'b1, 2, {dma_hold, cpu_stall}, 32'h1, "first cycle after reset");
    @(posedge clk); #1;
    chk(if_dma_gnt == 8'h20 && if_cpu_gnt == 0, 9, {if_dma_gnt, if_cpu_gnt}, 32'h2000, "one owner");
    drive(1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 43);
    @(posedge clk); #1;
    chk(if_dma_gnt == 0 && if_cpu_gnt == 0, 9, {if_dma_gnt, if_cpu_gnt}, 0, "grant lasts one cycle");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule